// File: doc/BRIEF.md
# PLL Lock and Calibration Supervisor

This block sits next to a clock-multiplier PLL and judges, in digital logic, whether the loop holds frequency lock. The reference clock defines a measurement window of 2^`WIN_LG2` reference cycles. Over each window the block counts edges of the divided feedback clock and compares the count with the window length. If the absolute difference exceeds the `lock_tol_i` input, the loop is out of tolerance. Lock is declared only after `LOCK_WINS` tolerant windows in a row. A single bad window drops it. While unlocked, the block emits a periodic reacquire pulse to the loop.

A toggle taken from the reference domain shows whether the reference clock is alive. If no toggle is seen for `REF_TIMEOUT` system cycles, loss-of-lock is forced high and all lock history is dropped. A single power-down/calibrate pin drives a small sequencer:
- While the pin is high, the output drivers are disabled and loss-of-lock is masked.
- On the falling edge, the lock state is cleared.
- Calibration runs only if the pin was high long enough and the reference is alive. Calibration lasts `CAL_CYC` cycles, and loss-of-lock stays masked for that time.

Top module: `pll_lock_supervisor`

## Requirements
- R1: In tracking with a live reference, a window whose feedback count differs from 2^WIN_LG2 by more than lock_tol_i is out of tolerance. A difference of lock_tol_i or less is tolerated, whichever sign it has.
- R2: The first window after reset, calibration, a power-down exit or a reference restart only primes the count. After that, lol_o falls only after LOCK_WINS consecutive tolerant windows.
- R3: Once locked, a single out-of-tolerance window raises lol_o.
- R4: While tracking and unlocked, reacq_o is a one-cycle pulse on every REACQ_WINS-th window. It is never high while lol_o is low.
- R5: If the reference stops, lol_o goes high within REF_TIMEOUT plus 12 system cycles, and not before REF_TIMEOUT minus 8. Lock is relearned once the reference returns.
- R6: lol_o is 0 in reset. It is 0 whenever pdn_cal_i has been sampled high on the last 4 system edges.
- R7: drv_en_o is 0 in reset and whenever pdn_cal_i has been high for 3 edges. It is 1 once pdn_cal_i has been low for 2 edges.
- R8: A falling edge of pdn_cal_i that follows at least HOLD_CYC synchronised high cycles, with a live reference, gives exactly one one-cycle cal_start_o pulse. It also clears the lock state, so lol_o is high after calibration.
- R9: A falling edge after a shorter hold, or with a dead reference, gives no cal_start_o. The block goes straight to tracking, unlocked.
- R10: lol_o is 0 in the cal_start_o cycle and the following CAL_CYC-1 cycles. With a live reference it is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset for all domains |
| ref_clk_i | input | 1 | Reference clock |
| fb_clk_i | input | 1 | Divided feedback clock from the PLL |
| pdn_cal_i | input | 1 | Power-down when high; falling edge may start calibration |
| lock_tol_i | input | TOL_W | Allowed count difference per window |
| lol_o | output | 1 | Loss-of-lock flag |
| drv_en_o | output | 1 | Output-driver enable |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| reacq_o | output | 1 | One-cycle reacquire request |

## Verification
The frequency comparison is driven with several feedback clocks:
- Equal to the reference.
- About 4 % slow, inside the tolerance.
- 20 % slow and 25 % fast, both outside it.

This separates a correct absolute difference from a one-sided one, and a correct threshold from an off-by-one. The step from the fast clock back into tolerance shows that a lock needs consecutive good windows. A stopped reference is checked both before and after the timeout, to bound when the forced flag appears. Power-down holds that are long, short, and long with a dead reference each tell whether calibration is gated on hold time and on reference activity. A cycle-level model tracks the calibration mask and the exact spacing of reacquire pulses.

// File: rtl/plk_pkg.sv
package plk_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_PDN   = 2'd1,
    ST_CAL   = 2'd2
  } plk_state_e;
endpackage

// File: rtl/plk_sync.sv
module plk_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= rst_val_i;
      s2_q <= rst_val_i;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/plk_ref_win.sv
module plk_ref_win #(
  parameter int WIN_LG2 = 6
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic win_tgl_o,
  output logic act_tgl_o
);
  logic [WIN_LG2-1:0] cnt_q;
  logic               win_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) win_q <= ~win_q;
    end
  end

  assign win_tgl_o = win_q;
  assign act_tgl_o = cnt_q[0];
endmodule

// File: rtl/plk_fb_cnt.sv
module plk_fb_cnt #(
  parameter int W = 9
) (
  input  logic         fb_clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q, gray_q, bin_nxt;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge fb_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/plk_ctrl.sv
module plk_ctrl
  import plk_pkg::*;
#(
  parameter int WIN_LG2     = 6,
  parameter int FBW         = 9,
  parameter int TOL_W       = 8,
  parameter int LOCK_WINS   = 3,
  parameter int REACQ_WINS  = 4,
  parameter int REF_TIMEOUT = 32,
  parameter int HOLD_CYC    = 250,
  parameter int CAL_CYC     = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdn_s_i,
  input  logic             win_tgl_s_i,
  input  logic             act_tgl_s_i,
  input  logic [FBW-1:0]   fb_gray_s_i,
  input  logic [TOL_W-1:0] tol_i,
  output logic             lol_o,
  output logic             drv_en_o,
  output logic             cal_start_o,
  output logic             reacq_o
);
  localparam int GD_W = $clog2(LOCK_WINS + 1);
  localparam int RQ_W = $clog2(REACQ_WINS + 1);
  localparam int TO_W = $clog2(REF_TIMEOUT + 1);
  localparam int HO_W = $clog2(HOLD_CYC + 1);
  localparam int CA_W = $clog2(CAL_CYC + 1);
  localparam logic [FBW-1:0]  EXP_CNT = FBW'(2 ** WIN_LG2);
  localparam logic [TO_W-1:0] TO_MAX  = TO_W'(REF_TIMEOUT);
  localparam logic [HO_W-1:0] HO_MAX  = HO_W'(HOLD_CYC);

  plk_state_e      state_q;
  logic            win_q, act_q, pdn_q;
  logic [TO_W-1:0] to_cnt_q;
  logic [HO_W-1:0] hold_q;
  logic [CA_W-1:0] cal_cnt_q;
  logic [GD_W-1:0] good_q;
  logic [RQ_W-1:0] rq_cnt_q;
  logic [FBW-1:0]  fb_prev_q, fb_bin, delta, absdiff;
  logic            locked_q, primed_q, cal_q, reacq_q;
  logic            win_evt, act_evt, pdn_fall, ref_ok, in_tol, will_lock;

  always_comb begin
    for (int i = 0; i < FBW; i++) fb_bin[i] = ^(fb_gray_s_i >> i);
  end

  assign win_evt   = win_tgl_s_i ^ win_q;
  assign act_evt   = act_tgl_s_i ^ act_q;
  assign pdn_fall  = pdn_q & ~pdn_s_i;
  assign ref_ok    = (to_cnt_q != TO_MAX);
  assign delta     = fb_bin - fb_prev_q;
  assign absdiff   = (delta >= EXP_CNT) ? (delta - EXP_CNT) : (EXP_CNT - delta);
  assign in_tol    = (absdiff <= FBW'(tol_i));
  assign will_lock = primed_q & in_tol & (good_q == GD_W'(LOCK_WINS - 1));

  // edge detectors, activity timeout, power-down hold time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= 1'b0;
      act_q    <= 1'b0;
      pdn_q    <= 1'b1;
      to_cnt_q <= '0;
      hold_q   <= '0;
    end else begin
      win_q <= win_tgl_s_i;
      act_q <= act_tgl_s_i;
      pdn_q <= pdn_s_i;
      if (act_evt)     to_cnt_q <= '0;
      else if (ref_ok) to_cnt_q <= to_cnt_q + 1'b1;
      if (!pdn_s_i)              hold_q <= '0;
      else if (hold_q != HO_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PDN;
      cal_cnt_q <= '0;
      locked_q  <= 1'b0;
      primed_q  <= 1'b0;
      good_q    <= '0;
      rq_cnt_q  <= '0;
      fb_prev_q <= '0;
      cal_q     <= 1'b0;
      reacq_q   <= 1'b0;
    end else begin
      cal_q   <= 1'b0;
      reacq_q <= 1'b0;
      if (pdn_s_i || pdn_fall) begin
        locked_q <= 1'b0;
        primed_q <= 1'b0;
        good_q   <= '0;
        rq_cnt_q <= '0;
        if (pdn_s_i) begin
          state_q <= ST_PDN;
        end else if ((hold_q == HO_MAX) && ref_ok) begin
          state_q   <= ST_CAL;
          cal_cnt_q <= '0;
          cal_q     <= 1'b1;
        end else begin
          state_q <= ST_TRACK;
        end
      end else begin
        unique case (state_q)
          ST_CAL: begin
            cal_cnt_q <= cal_cnt_q + 1'b1;
            if (cal_cnt_q == CA_W'(CAL_CYC - 1)) state_q <= ST_TRACK;
          end
          ST_TRACK: begin
            if (!ref_ok) begin
              locked_q <= 1'b0;
              primed_q <= 1'b0;
              good_q   <= '0;
              rq_cnt_q <= '0;
            end else if (win_evt) begin
              fb_prev_q <= fb_bin;
              primed_q  <= 1'b1;
              if (primed_q) begin
                if (!in_tol) begin
                  locked_q <= 1'b0;
                  good_q   <= '0;
                end else if (will_lock) begin
                  locked_q <= 1'b1;
                end else begin
                  good_q <= good_q + 1'b1;
                end
              end
              if (will_lock) begin
                rq_cnt_q <= '0;
              end else if (!locked_q) begin
                if (rq_cnt_q == RQ_W'(REACQ_WINS - 1)) begin
                  rq_cnt_q <= '0;
                  reacq_q  <= 1'b1;
                end else begin
                  rq_cnt_q <= rq_cnt_q + 1'b1;
                end
              end
            end
          end
          default: state_q <= ST_TRACK;
        endcase
      end
    end
  end

  assign lol_o       = (state_q == ST_TRACK) & (~locked_q | ~ref_ok);
  assign drv_en_o    = ~pdn_s_i;
  assign cal_start_o = cal_q;
  assign reacq_o     = reacq_q;
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor #(
  parameter int WIN_LG2     = 6,
  parameter int FB_XTRA     = 3,
  parameter int TOL_W       = 8,
  parameter int LOCK_WINS   = 3,
  parameter int REACQ_WINS  = 4,
  parameter int REF_TIMEOUT = 32,
  parameter int HOLD_CYC    = 250,
  parameter int CAL_CYC     = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic             pdn_cal_i,
  input  logic [TOL_W-1:0] lock_tol_i,
  output logic             lol_o,
  output logic             drv_en_o,
  output logic             cal_start_o,
  output logic             reacq_o
);
  localparam int FBW = WIN_LG2 + FB_XTRA;

  logic           win_tgl, act_tgl;
  logic [FBW-1:0] fb_gray, fb_gray_s;
  logic [2:0]     bits_s;

  plk_ref_win #(.WIN_LG2(WIN_LG2)) u_ref_win (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .win_tgl_o (win_tgl),
    .act_tgl_o (act_tgl)
  );

  plk_fb_cnt #(.W(FBW)) u_fb_cnt (
    .fb_clk_i (fb_clk_i),
    .rst_ni   (rst_ni),
    .gray_o   (fb_gray)
  );

  // bit 2: power-down (resets high), bit 1: window toggle, bit 0: activity
  plk_sync #(.W(3)) u_sync_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (3'b100),
    .d_i       ({pdn_cal_i, win_tgl, act_tgl}),
    .q_o       (bits_s)
  );

  plk_sync #(.W(FBW)) u_sync_fb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i ('0),
    .d_i       (fb_gray),
    .q_o       (fb_gray_s)
  );

  plk_ctrl #(
    .WIN_LG2     (WIN_LG2),
    .FBW         (FBW),
    .TOL_W       (TOL_W),
    .LOCK_WINS   (LOCK_WINS),
    .REACQ_WINS  (REACQ_WINS),
    .REF_TIMEOUT (REF_TIMEOUT),
    .HOLD_CYC    (HOLD_CYC),
    .CAL_CYC     (CAL_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pdn_s_i     (bits_s[2]),
    .win_tgl_s_i (bits_s[1]),
    .act_tgl_s_i (bits_s[0]),
    .fb_gray_s_i (fb_gray_s),
    .tol_i       (lock_tol_i),
    .lol_o       (lol_o),
    .drv_en_o    (drv_en_o),
    .cal_start_o (cal_start_o),
    .reacq_o     (reacq_o)
  );
endmodule

// File: rtl/plk_checker.sv
module plk_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pdn_cal_i,
  input logic lol_o,
  input logic drv_en_o,
  input logic cal_start_o,
  input logic reacq_o
);
  AST_PDN_MASKS_LOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_cal_i && $past(pdn_cal_i) && $past(pdn_cal_i, 2) && $past(pdn_cal_i, 3)) |-> !lol_o); // R6

  AST_PDN_DRV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_cal_i && $past(pdn_cal_i) && $past(pdn_cal_i, 2)) |-> !drv_en_o); // R7

  AST_CAL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_start_o); // R8

  AST_CAL_MASKS_LOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> !lol_o); // R10

  AST_REACQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reacq_o |=> !reacq_o); // R4

  AST_REACQ_WHILE_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reacq_o |-> lol_o); // R4

  AST_NO_DUAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cal_start_o && reacq_o)); // R8
endmodule

bind pll_lock_supervisor plk_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pdn_cal_i   (pdn_cal_i),
  .lol_o       (lol_o),
  .drv_en_o    (drv_en_o),
  .cal_start_o (cal_start_o),
  .reacq_o     (reacq_o)
);

// File: tb/sim_pll_lock_supervisor.sv
`timescale 1ns/1ps
module sim_pll_lock_supervisor;
  localparam int CAL_CYC  = 64;
  localparam int TIMEOUT  = 32;
  localparam int WIN_CYC  = 320;  // 64 ref cycles of 20 ns at 4 ns per clock
  localparam int REACQ_W  = 4;

  logic       clk = 1'b0, ref_clk = 1'b0, fb_clk = 1'b0;
  logic       rst_n = 1'b0, pdn = 1'b0, ref_run = 1'b1;
  logic [7:0] tol = 8'd4;
  logic       lol, drv_en, cal_start, reacq;
  real        fb_half = 10.0;

  int compared = 0, mismatched = 0;
  int cyc = 0, pdn_run = 0, low_run = 0, cidx = CAL_CYC + 1;
  int last_rq = -1, reacq_seen = 0, cal_seen = 0;
  bit prev_rq = 1'b0;

  always #2 clk = ~clk;
  always #10 if (ref_run) ref_clk = ~ref_clk;
  always #(fb_half) fb_clk = ~fb_clk;

  pll_lock_supervisor u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_clk_i   (ref_clk),
    .fb_clk_i    (fb_clk),
    .pdn_cal_i   (pdn),
    .lock_tol_i  (tol),
    .lol_o       (lol),
    .drv_en_o    (drv_en),
    .cal_start_o (cal_start),
    .reacq_o     (reacq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycle-level reference model, sampled 1 ns after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      cyc++;
      pdn_run = pdn ? pdn_run + 1 : 0;
      low_run = pdn ? 0 : low_run + 1;
      if (pdn_run >= 4) chk(lol == 1'b0, "R6 lol masked in power-down", lol, 0);
      if (pdn_run >= 3) chk(drv_en == 1'b0, "R7 drivers off", drv_en, 0);
      if (low_run >= 2) chk(drv_en == 1'b1, "R7 drivers on", drv_en, 1);
      if (cal_start) begin
        cal_seen++;
        cidx = 0;
      end else if (cidx <= CAL_CYC) begin
        cidx++;
      end
      if (cidx < CAL_CYC) chk(lol == 1'b0, "R10 lol masked in calibration", lol, 0);
      if (cidx == CAL_CYC && !pdn && ref_run)
        chk(lol == 1'b1, "R10 unlocked after calibration", lol, 1);
      if (prev_rq && reacq) chk(1'b0, "R4 reacq width", 2, 1);
      if (lol == 1'b0 || pdn || !ref_run || cidx < CAL_CYC) last_rq = -1;
      if (reacq && !prev_rq) begin
        reacq_seen++;
        if (last_rq >= 0)
          chk((cyc - last_rq) >= REACQ_W * WIN_CYC - 2 && (cyc - last_rq) <= REACQ_W * WIN_CYC + 2,
              "R4 reacq spacing", cyc - last_rq, REACQ_W * WIN_CYC);
        last_rq = cyc;
      end
      prev_rq = reacq;
    end else begin
      pdn_run = 0;
      low_run = 0;
    end
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int c0, r0;
    wait_cyc(8);
    chk(lol == 1'b0, "R6 reset lol", lol, 0);
    chk(drv_en == 1'b0, "R7 reset drv_en", drv_en, 0);
    chk(cal_start == 1'b0, "R8 reset cal_start", cal_start, 0);
    chk(reacq == 1'b0, "R4 reset reacq", reacq, 0);
    rst_n = 1'b1;

    // equal frequencies: priming plus consecutive good windows
    wait_cyc(900);
    chk(lol == 1'b1, "R2 not yet locked", lol, 1);
    wait_cyc(1100);
    chk(lol == 1'b0, "R2 locked on equal clocks", lol, 0);
    chk(drv_en == 1'b1, "R7 drivers on in tracking", drv_en, 1);

    // fast feedback, 80 counts per window
    fb_half = 8.0;
    wait_cyc(680);
    chk(lol == 1'b1, "R3 fast feedback drops lock", lol, 1);
    r0 = reacq_seen;
    wait_cyc(10 * WIN_CYC);
    chk((reacq_seen - r0) >= 2 && (reacq_seen - r0) <= 3, "R4 reacq pulses while unlocked",
        reacq_seen - r0, 2);

    // slightly slow feedback, about 61.5 counts: inside tolerance 4
    fb_half = 10.4;
    wait_cyc(2 * WIN_CYC);
    chk(lol == 1'b1, "R2 needs consecutive good windows", lol, 1);
    wait_cyc(1400);
    chk(lol == 1'b0, "R1 small offset tolerated", lol, 0);

    // slow feedback, about 51 counts
    fb_half = 12.5;
    wait_cyc(680);
    chk(lol == 1'b1, "R1 slow feedback out of tolerance", lol, 1);
    fb_half = 10.0;
    wait_cyc(2000);
    chk(lol == 1'b0, "R2 relock after slow feedback", lol, 0);

    // dead reference
    ref_run = 1'b0;
    wait_cyc(TIMEOUT - 8);
    chk(lol == 1'b0, "R5 no early dead-reference flag", lol, 0);
    wait_cyc(20);
    chk(lol == 1'b1, "R5 dead reference forces lol", lol, 1);

    // long power-down with dead reference
    pdn = 1'b1;
    wait_cyc(300);
    chk(lol == 1'b0, "R6 lol masked with dead reference", lol, 0);
    chk(drv_en == 1'b0, "R7 drivers off in power-down", drv_en, 0);
    c0 = cal_seen;
    pdn = 1'b0;
    wait_cyc(100);
    chk(cal_seen == c0, "R9 no calibration on dead reference", cal_seen - c0, 0);
    chk(lol == 1'b1, "R5 lol high after exit on dead reference", lol, 1);
    chk(drv_en == 1'b1, "R7 drivers back on", drv_en, 1);

    ref_run = 1'b1;
    wait_cyc(2600);
    chk(lol == 1'b0, "R5 relock after reference returns", lol, 0);

    // hold shorter than the minimum
    pdn = 1'b1;
    wait_cyc(230);
    c0 = cal_seen;
    pdn = 1'b0;
    wait_cyc(20);
    chk(cal_seen == c0, "R9 short hold gives no calibration", cal_seen - c0, 0);
    chk(lol == 1'b1, "R9 lock cleared on short hold", lol, 1);
    wait_cyc(2600);
    chk(lol == 1'b0, "R2 relock after short hold", lol, 0);

    // hold longer than the minimum with a live reference
    pdn = 1'b1;
    wait_cyc(270);
    c0 = cal_seen;
    pdn = 1'b0;
    wait_cyc(20);
    chk(cal_seen == c0 + 1, "R8 one calibration pulse", cal_seen - c0, 1);
    wait_cyc(100);
    chk(lol == 1'b1, "R8 lock cleared by calibration", lol, 1);
    wait_cyc(2600);
    chk(lol == 1'b0, "R10 relock after calibration", lol, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule